// File: doc/BRIEF.md
# Reconfiguration Recovery Watchdog

This block is an external supervisor that sits next to a reconfigurable device and drives that device's configuration pins. A processor inside the device shows that it is alive by toggling a general-purpose output. Each rising edge on that line restarts a programmable window. If the window runs out, the supervisor drives the program line low to force the device to reload its initial configuration image. It holds the device in reset until the device raises its configuration-done flag.

The same path serves a planned reboot. When firmware wants to start an update download, it stops toggling the refresh line on purpose. The device then returns to its initial image, which holds the logic the download needs. A reload can fail because configuration-done does not arrive within a second programmable timeout. In that case the program pulse is issued again and a saturating retry count is incremented. Once configuration-done is seen, a fixed grace period lets the firmware restart before refreshes are required again.

Top module: `cfg_recovery_wdog`

## Requirements
- R1: While `rst_n` is low, `prog_n_o` is low, `dev_rst_n_o` is low, `st_reload_o` is high and `retry_cnt_o` is zero. Leaving reset completes a program pulse and then releases `prog_n_o`.
- R2: Every program pulse holds `prog_n_o` low for exactly `PULSE_CYC` clock cycles.
- R3: `dev_rst_n_o` is low whenever `prog_n_o` is low. It stays low until configuration-done has been seen, and it rises only when the grace phase starts.
- R4: After configuration-done is seen, `st_grace_o` is high for exactly `GRACE_CYC` cycles. No timeout can occur in this phase. It is followed by the armed phase (`st_armed_o`).
- R5: In the armed phase, each rising edge of `refresh_i` restarts the window. Rising edges that arrive at intervals shorter than `window_i` cycles keep `prog_n_o` high indefinitely.
- R6: A refresh line that stops toggling starts a program pulse. This holds whether the line is held high or low, and it is how firmware forces a planned reboot. `prog_n_o` falls no earlier than `window_i`+1 and no later than `window_i`+5 cycles after the last accepted rising edge is applied.
- R7: After a program pulse ends, if configuration-done has not been seen, a new pulse begins exactly `done_tmo_i`+1 cycles after `prog_n_o` rose. `retry_cnt_o` increments by one when that new pulse begins.
- R8: `retry_cnt_o` saturates at its all-ones value. It never decreases except through reset, and a successful reload leaves it unchanged.
- R9: Exactly one of `st_grace_o`, `st_armed_o` and `st_reload_o` is high at all times. `st_reload_o` covers both the pulse and the wait for configuration-done.
- R10: Rising edges on `refresh_i` during a program pulse or during the wait for configuration-done have no effect on the timing of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_i | input | 1 | Refresh strobe from the device's general-purpose output (asynchronous) |
| window_i | input | CW | Refresh window length in cycles |
| cfg_done_i | input | 1 | Configuration-done flag from the device (asynchronous) |
| done_tmo_i | input | CW | Cycles allowed for configuration-done after the pulse ends |
| prog_n_o | output | 1 | Program line to the device, active low |
| dev_rst_n_o | output | 1 | Device reset, active low |
| st_grace_o | output | 1 | Grace phase after a successful reload |
| st_armed_o | output | 1 | Refresh window is being enforced |
| st_reload_o | output | 1 | Program pulse or wait for configuration-done in progress |
| retry_cnt_o | output | RW | Saturating count of configuration-done timeouts |

## Verification
A wrong phase register would appear at once as an illegal mix of the three status flags, or as `prog_n_o` and `dev_rst_n_o` disagreeing in the same cycle. A wrong timer load would show up within one window as a pulse of the wrong width, a grace phase of the wrong length, or a trip that falls outside the allowed window. The bench checks those lengths to the exact cycle. A corrupt retry count would be visible on `retry_cnt_o` at the first configuration-done timeout, and it would stay visible through the next successful reload.

// File: rtl/wdog_pkg.sv
// Shared types for the reconfiguration recovery watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdog_pkg;
    typedef enum logic [1:0] {
        PH_PULSE = 2'd0,   // program line driven low
        PH_WAIT  = 2'd1,   // waiting for configuration-done
        PH_GRACE = 2'd2,   // firmware start-up allowance
        PH_ARMED = 2'd3    // refresh window enforced
    } wdog_phase_e;
endpackage

// File: rtl/wdog_sync.sv
// Multi-flop synchronizer for an asynchronous input. The RISE_ONLY variant
// gives a one-cycle pulse per rising edge instead of the level.
// Assumes: STAGES >= 2; the input is a slow level signal.
module wdog_sync #(
    parameter int STAGES    = 2,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    generate
        if (RISE_ONLY) begin : g_rise
            logic last_q;
            // Remember the previous synchronized level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= 1'b0;
                else        last_q <= chain_q[STAGES-1];
            end
            assign q_o = chain_q[STAGES-1] & ~last_q;
        end else begin : g_level
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wdog_timer.sv
// Shared down-counter. It loads on request, counts down to zero and holds there.
// Assumes: one load request per cycle at most; load wins over counting.
module wdog_timer #(
    parameter int CW       = 16,
    parameter int INIT_VAL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    localparam logic [CW-1:0] INIT_C = CW'(INIT_VAL);
    logic [CW-1:0] cnt_q;

    // Load a new interval or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= INIT_C;
        else if (load_i)          cnt_q <= load_val_i;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wdog_retry.sv
// Saturating counter of configuration-done timeouts; only reset clears it.
// Assumes: bump_i is a single-cycle strobe.
module wdog_retry #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bump_i,
    output logic [RW-1:0] count_o
);
    logic [RW-1:0] cnt_q;

    // Count timeouts, sticking at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (bump_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/wdog_fsm.sv
// Phase sequencer: pulse -> wait for done -> grace -> armed -> pulse.
// It picks the timer interval for each phase and flags done timeouts.
// Assumes: refresh_rise_i and done_i are already synchronized.
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CW        = 16,
    parameter int PULSE_CYC = 4,
    parameter int GRACE_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          refresh_rise_i,
    input  logic          done_i,
    input  logic          timer_zero_i,
    input  logic [CW-1:0] window_i,
    input  logic [CW-1:0] done_tmo_i,
    output wdog_phase_e   phase_o,
    output logic          load_o,
    output logic [CW-1:0] load_val_o,
    output logic          retry_bump_o
);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] GRACE_LD = CW'(GRACE_CYC - 1);

    wdog_phase_e phase_q, phase_d;

    // Hold the current phase; reset starts with a program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_PULSE;
        else        phase_q <= phase_d;
    end

    // Choose the next phase and the interval to load into the timer.
    always_comb begin
        phase_d      = phase_q;
        load_o       = 1'b0;
        load_val_o   = '0;
        retry_bump_o = 1'b0;
        unique case (phase_q)
            PH_PULSE: begin
                if (timer_zero_i) begin
                    phase_d    = PH_WAIT;
                    load_o     = 1'b1;
                    load_val_o = done_tmo_i;
                end
            end
            PH_WAIT: begin
                if (done_i) begin
                    phase_d    = PH_GRACE;
                    load_o     = 1'b1;
                    load_val_o = GRACE_LD;
                end else if (timer_zero_i) begin
                    phase_d      = PH_PULSE;
                    load_o       = 1'b1;
                    load_val_o   = PULSE_LD;
                    retry_bump_o = 1'b1;
                end
            end
            PH_GRACE: begin
                if (timer_zero_i) begin
                    phase_d    = PH_ARMED;
                    load_o     = 1'b1;
                    load_val_o = window_i;
                end
            end
            PH_ARMED: begin
                if (timer_zero_i) begin
                    phase_d    = PH_PULSE;
                    load_o     = 1'b1;
                    load_val_o = PULSE_LD;
                end else if (refresh_rise_i) begin
                    load_o     = 1'b1;
                    load_val_o = window_i;
                end
            end
            default: phase_d = PH_PULSE;
        endcase
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/cfg_recovery_wdog.sv
// Reconfiguration recovery watchdog. It supervises a reconfigurable device
// through refresh edges and forces a full configuration reload when
// refreshes stop, retrying the reload if configuration-done never arrives.
// Assumes: PULSE_CYC >= 2, GRACE_CYC >= 1, SYNC_STAGES >= 2.
module cfg_recovery_wdog
    import wdog_pkg::*;
#(
    parameter int CW          = 16,
    parameter int RW          = 4,
    parameter int PULSE_CYC   = 4,
    parameter int GRACE_CYC   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          refresh_i,
    input  logic [CW-1:0] window_i,
    input  logic          cfg_done_i,
    input  logic [CW-1:0] done_tmo_i,
    output logic          prog_n_o,
    output logic          dev_rst_n_o,
    output logic          st_grace_o,
    output logic          st_armed_o,
    output logic          st_reload_o,
    output logic [RW-1:0] retry_cnt_o
);
    logic          refresh_rise;
    logic          done_sync;
    logic          tmr_zero;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          retry_bump;
    wdog_phase_e   phase;

    wdog_sync #(.STAGES(SYNC_STAGES), .RISE_ONLY(1'b1)) u_refresh_sync (
        .clk(clk), .rst_n(rst_n), .d_i(refresh_i), .q_o(refresh_rise)
    );

    wdog_sync #(.STAGES(SYNC_STAGES), .RISE_ONLY(1'b0)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cfg_done_i), .q_o(done_sync)
    );

    wdog_timer #(.CW(CW), .INIT_VAL(PULSE_CYC - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .zero_o(tmr_zero)
    );

    wdog_fsm #(.CW(CW), .PULSE_CYC(PULSE_CYC), .GRACE_CYC(GRACE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .refresh_rise_i(refresh_rise),
        .done_i(done_sync), .timer_zero_i(tmr_zero),
        .window_i(window_i), .done_tmo_i(done_tmo_i),
        .phase_o(phase), .load_o(tmr_load), .load_val_o(tmr_val),
        .retry_bump_o(retry_bump)
    );

    wdog_retry #(.RW(RW)) u_retry (
        .clk(clk), .rst_n(rst_n), .bump_i(retry_bump), .count_o(retry_cnt_o)
    );

    // Decode the registered phase onto the device pins and status flags.
    always_comb begin
        prog_n_o    = (phase != PH_PULSE);
        st_reload_o = (phase == PH_PULSE) || (phase == PH_WAIT);
        st_grace_o  = (phase == PH_GRACE);
        st_armed_o  = (phase == PH_ARMED);
        dev_rst_n_o = !st_reload_o;
    end
endmodule

// File: rtl/cfg_recovery_wdog_chk.sv
// Port-level checker for the recovery watchdog, bound into every instance.
// Assumes: PULSE_CYC >= 2.
module cfg_recovery_wdog_chk #(
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_n_o,
    input logic          dev_rst_n_o,
    input logic          st_grace_o,
    input logic          st_armed_o,
    input logic          st_reload_o,
    input logic [RW-1:0] retry_cnt_o
);
    a_r3_prog_implies_rst: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !dev_rst_n_o);

    a_r3_release_into_grace: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n_o) |-> st_grace_o);

    a_r9_one_phase_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_grace_o, st_armed_o, st_reload_o}) == 1);

    a_r8_retry_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> retry_cnt_o >= $past(retry_cnt_o));

    a_r4_grace_then_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_grace_o) |-> st_armed_o);

    a_r6_armed_exits_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_armed_o) |-> !prog_n_o);

    a_r2_pulse_not_single: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n_o) |=> !prog_n_o);
endmodule

bind cfg_recovery_wdog cfg_recovery_wdog_chk #(.RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_n_o(prog_n_o), .dev_rst_n_o(dev_rst_n_o),
    .st_grace_o(st_grace_o), .st_armed_o(st_armed_o),
    .st_reload_o(st_reload_o), .retry_cnt_o(retry_cnt_o)
);

// File: tb/cfg_recovery_wdog_tb.sv
// Directed bench: one task per scenario, a behavioural device model that
// answers the program line, and counters for checks and failures.
module cfg_recovery_wdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int RW = 4;
    localparam int PULSE_CYC = 4;
    localparam int GRACE_CYC = 8;
    localparam int WIN = 40;
    localparam int DTMO = 20;
    localparam int DEV_LAT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh = 1'b0;
    logic [CW-1:0] window = CW'(WIN);
    logic          cfg_done = 1'b0;
    logic [CW-1:0] done_tmo = CW'(DTMO);
    logic          prog_n, dev_rst_n, st_grace, st_armed, st_reload;
    logic [RW-1:0] retry_cnt;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  finished = 1'b0;
    bit  dev_alive = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_recovery_wdog #(.CW(CW), .RW(RW), .PULSE_CYC(PULSE_CYC),
                        .GRACE_CYC(GRACE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_i(refresh), .window_i(window),
        .cfg_done_i(cfg_done), .done_tmo_i(done_tmo), .prog_n_o(prog_n),
        .dev_rst_n_o(dev_rst_n), .st_grace_o(st_grace), .st_armed_o(st_armed),
        .st_reload_o(st_reload), .retry_cnt_o(retry_cnt)
    );

    // Device model: done drops during the program pulse and returns
    // DEV_LAT cycles after release, but only while the device is healthy.
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (!prog_n) begin
                cfg_done = 1'b0;
                lat = 0;
            end else if (dev_alive && !cfg_done) begin
                lat++;
                if (lat >= DEV_LAT) cfg_done = 1'b1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_armed();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (st_armed) break;
        end
    endtask

    // Count cycles from raising refresh (held high) until prog_n falls.
    task automatic cycles_to_trip(input bit hold_high, output int n);
        @(negedge clk);
        refresh = 1'b1;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            if (!hold_high && n == 2) refresh = 1'b0;
            if (!prog_n) break;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 prog_n in reset", prog_n, 0);
        check("R1 dev_rst_n in reset", dev_rst_n, 0);
        check("R1 reload flag in reset", st_reload, 1);
        check("R1 retry in reset", retry_cnt, 0);
    endtask

    task automatic t_power_on();
        int g;
        rst_n = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (prog_n) break;
        end
        check("R1 pulse released after reset", prog_n, 1);
        check("R3 dev_rst_n held while waiting", dev_rst_n, 0);
        for (int i = 0; i < 100; i++) begin
            if (st_grace) break;
            @(negedge clk);
        end
        g = 0;
        while (st_grace && g < 100) begin
            check("R3 dev_rst_n released in grace", dev_rst_n, 1);
            @(negedge clk);
            g++;
        end
        check("R4 grace length", g, GRACE_CYC);
        check("R9 armed after grace", {st_grace, st_armed, st_reload}, 3'b010);
        check("R8 retry after clean reload", retry_cnt, 0);
    endtask

    task automatic t_keepalive();
        int lows;
        lows = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); refresh = 1'b1;
            @(negedge clk); if (!prog_n) lows++;
            @(negedge clk); if (!prog_n) lows++;
            refresh = 1'b0;
            for (int j = 0; j < 15; j++) begin
                @(negedge clk);
                if (!prog_n) lows++;
            end
        end
        check("R5 regular refresh keeps prog_n high", lows, 0);
        check("R5 still armed", st_armed, 1);
    endtask

    task automatic t_stuck_high();
        int n, w;
        cycles_to_trip(1'b1, n);
        check_range("R6 trip with refresh stuck high", n, WIN + 1, WIN + 5);
        w = 0;
        while (!prog_n && w < 50) begin
            check("R3 dev_rst_n low during pulse", dev_rst_n, 0);
            w++;
            @(negedge clk);
        end
        check("R2 pulse width after trip", w, PULSE_CYC);
        wait_armed();
        refresh = 1'b0;
        check("R8 retry unchanged after clean reload", retry_cnt, 0);
    endtask

    task automatic t_fw_reboot();
        int n;
        cycles_to_trip(1'b0, n);
        check_range("R6 planned reboot by stopping refresh", n, WIN + 1, WIN + 5);
        wait_armed();
        check("R3 dev_rst_n high once armed again", dev_rst_n, 1);
    endtask

    task automatic t_done_timeout();
        int n, w;
        dev_alive = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!prog_n) break;
        end
        while (!prog_n) @(negedge clk);
        // prog_n has just risen; refresh edges are applied while waiting (R10).
        n = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!prog_n) break;
            n++;
            refresh = n[1];
        end
        refresh = 1'b0;
        check("R7 R10 done timeout to retry pulse", n, DTMO + 1);
        check("R7 retry incremented", retry_cnt, 1);
        w = 0;
        while (!prog_n && w < 50) begin
            w++;
            @(negedge clk);
        end
        check("R2 retry pulse width", w, PULSE_CYC);
        for (int k = 0; k < 18; k++) begin
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!prog_n) break;
            end
            while (!prog_n) @(negedge clk);
        end
        check("R8 retry saturates", retry_cnt, (1 << RW) - 1);
        dev_alive = 1'b1;
        wait_armed();
        check("R8 retry kept after recovery", retry_cnt, (1 << RW) - 1);
        check("R3 device out of reset after recovery", dev_rst_n, 1);
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset clears retry", retry_cnt, 0);
        check("R1 prog_n low on second reset", prog_n, 0);
        rst_n = 1'b1;
        wait_armed();
        check("R9 armed after reset recovery", st_armed, 1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_power_on();
        t_keepalive();
        t_stuck_high();
        t_fw_reboot();
        t_done_timeout();
        t_reset_clears();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule